// File: doc/BRIEF.md
# Two-Source Interrupt Acceptance Controller

This block decides when a small 4-bit processor core leaves its instruction stream to service an interrupt. There are two request sources: a level on an external pin, which is filtered and synchronised, and an underflow pulse from timer 1. Each source has a sticky request flag. A 4-bit control register holds a per-source enable, and the block also keeps one global enable flag that the core sets and clears with its enable and disable instructions.

An interrupt is accepted only while the global enable, the source enable and the source request are all set. Acceptance waits a fixed number of machine cycles after that condition is first seen. The wait is two cycles when the instruction running at that moment takes one machine cycle, and three cycles otherwise. On acceptance the block raises a one-clock strobe on the last clock of a machine cycle, which tells the core to push its return address and jump. It also reports which vector to use, clears the serviced request and clears the global enable. Software can poll a request flag with a skip query, but only while that source's interrupt is disabled.

Top module: `intr_accept_ctrl`

## Requirements
- R1: After reset `ctl_q` is 0000. A clock with `ctl_wr` high loads `acc_in` into it. Bit 0 enables the external source, bit 1 enables the timer source, bit 2 runs the timer and bit 3 selects the shared pin function.
- R2: A clock with `sleep_enter` high clears `ctl_q` to 0000, even when `ctl_wr` is high in the same clock.
- R3: `gie` is 0 after reset. A clock with `ei_op` high sets it and a clock with `di_op` high clears it. If both are high, the disable wins.
- R4: `ext_req` is set when `ext_pin` goes high, passes a two-flop synchroniser, and then stays high for 5 consecutive clocks. A high level that lasts a shorter time sets nothing.
- R5: A clock with `tmr_uflow` high sets `tmr_req`.
- R6: `take_irq` is never high unless `gie`, the source's enable bit in `ctl_q` and that source's request flag are all 1.
- R7: Take N as the `mc_tick` at which the acceptance condition is first seen true. `take_irq` pulses on the 2nd `mc_tick` after N if `insn_single` was high at N, and on the 3rd otherwise. The pulse lasts one clock and only comes with `mc_tick`.
- R8: On acceptance, `irq_vec` is 0 for the external source and 1 for the timer. The external source wins when both qualify. The next clock shows `gie` at 0 and the serviced flag cleared, while the other flag is kept.
- R9: `snz_ext` (or `snz_tmr`) drives `skip` high only when that source's enable bit is 0 and its flag is 1, and a skip clears that flag. When the enable bit is 1, `skip` stays 0 and the flag is kept.
- R10: If the condition drops during the wait, for example because of a disable instruction, the pending acceptance is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mc_tick | input | 1 | High on the last clock phase of each machine cycle |
| insn_single | input | 1 | Current instruction is one machine cycle long |
| ext_pin | input | 1 | Raw external interrupt pin |
| tmr_uflow | input | 1 | Timer 1 underflow pulse |
| acc_in | input | 4 | Accumulator value for control register writes |
| ctl_wr | input | 1 | Load control register from accumulator |
| sleep_enter | input | 1 | Low-power entry, clears control register |
| ei_op | input | 1 | Enable-interrupts instruction |
| di_op | input | 1 | Disable-interrupts instruction |
| snz_ext | input | 1 | Skip query on external request flag |
| snz_tmr | input | 1 | Skip query on timer request flag |
| ctl_q | output | 4 | Control register, read back to accumulator |
| gie | output | 1 | Global interrupt enable flag |
| ext_req | output | 1 | External request flag |
| tmr_req | output | 1 | Timer request flag |
| skip | output | 1 | Skip the next instruction |
| take_irq | output | 1 | Accept strobe: push return address, jump |
| irq_vec | output | 1 | Vector of the accepted source (0 ext, 1 timer) |

## Verification
The assertions assume that `mc_tick` is a single-clock pulse, that the core never issues both skip queries in the same clock, and that `insn_single` is meaningful at each `mc_tick`. The stimulus generates `mc_tick` from a free-running four-phase counter. It issues skip, enable and disable instructions one at a time and changes inputs only away from the active edge. It then walks both delay lengths, simultaneous requests, a disable during the wait and short pin glitches.

// File: rtl/intr_pkg.sv
// Shared definitions for the interrupt acceptance controller.
// Assumes: two sources, with the external source at index 0 (highest priority).
package intr_pkg;
    localparam int CTL_W      = 4;
    localparam int N_SRC      = 2;
    localparam int IDX_EXT    = 0;
    localparam int IDX_TMR    = 1;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_TMR = 1'b1
    } intr_src_e;
endpackage

// File: rtl/intr_pin_qual.sv
// Synchronises the raw external pin and qualifies it by time: the new level
// is adopted only after it has differed from the held level for STABLE_CLKS
// consecutive clocks. Emits a one-clock pulse when the adopted level turns high.
// Assumes: pin_raw is asynchronous to clk.
module intr_pin_qual #(
    parameter int STABLE_CLKS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_raw,
    output logic rise_ok
);
    localparam int RW = $clog2(STABLE_CLKS + 1);

    logic          s_meta, s_sync, level;
    logic [RW-1:0] run;
    logic          at_limit;

    assign at_limit = (run == RW'(STABLE_CLKS - 1));
    assign rise_ok  = (s_sync != level) && at_limit && s_sync;

    // Two-flop synchroniser followed by the stability counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            level  <= 1'b0;
            run    <= '0;
        end else begin
            s_meta <= pin_raw;
            s_sync <= s_meta;
            if (s_sync == level) begin
                run <= '0;
            end else if (at_limit) begin
                level <= s_sync;
                run   <= '0;
            end else begin
                run <= run + RW'(1);
            end
        end
    end
endmodule

// File: rtl/intr_req_flags.sv
// Bank of sticky request flags. A set in the same clock as a clear wins,
// so that a fresh event is never lost.
// Assumes: set and clr are single-clock qualified strobes.
module intr_req_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        // One sticky flag per source.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= 1'b0;
            else        q[i] <= set[i] | (q[i] & ~clr[i]);
        end
    end
endmodule

// File: rtl/intr_accept_seq.sv
// Acceptance delay sequencer. At the first machine-cycle tick where the
// condition is seen, it arms with a delay chosen by the instruction length.
// It then counts ticks and fires on the last one. It disarms whenever the
// condition drops.
// Assumes: mc_tick is a one-clock pulse per machine cycle.
module intr_accept_seq #(
    parameter int SHORT_DLY = 2,
    parameter int LONG_DLY  = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mc_tick,
    input  logic insn_single,
    input  logic cond,
    output logic take
);
    localparam int CW = $clog2(LONG_DLY + 1);

    logic          armed;
    logic [CW-1:0] cnt;
    logic          last;

    assign last = (cnt == CW'(1));
    assign take = mc_tick && armed && last && cond;

    // Arm, count down or disarm the pending acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (!cond) begin
            armed <= 1'b0;
        end else if (mc_tick) begin
            if (!armed) begin
                armed <= 1'b1;
                cnt   <= insn_single ? CW'(SHORT_DLY) : CW'(LONG_DLY);
            end else if (last) begin
                armed <= 1'b0;
            end else begin
                cnt <= cnt - CW'(1);
            end
        end
    end
endmodule

// File: rtl/intr_accept_ctrl.sv
// Interrupt acceptance controller top. It holds the control register, the
// global enable and the request flags, selects the vector with external
// priority, and answers skip queries while a source is disabled.
// Assumes: skip queries come one at a time; sleep_enter overrides ctl_wr.
module intr_accept_ctrl
    import intr_pkg::*;
#(
    parameter int STABLE_CLKS = 5,
    parameter int SHORT_DLY   = 2,
    parameter int LONG_DLY    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mc_tick,
    input  logic             insn_single,
    input  logic             ext_pin,
    input  logic             tmr_uflow,
    input  logic [CTL_W-1:0] acc_in,
    input  logic             ctl_wr,
    input  logic             sleep_enter,
    input  logic             ei_op,
    input  logic             di_op,
    input  logic             snz_ext,
    input  logic             snz_tmr,
    output logic [CTL_W-1:0] ctl_q,
    output logic             gie,
    output logic             ext_req,
    output logic             tmr_req,
    output logic             skip,
    output logic             take_irq,
    output logic             irq_vec
);
    logic [N_SRC-1:0] f_set, f_clr, f_q, qual, skip_hit;
    logic             pin_rise, take, cond;
    intr_src_e        win_src;

    intr_pin_qual #(.STABLE_CLKS(STABLE_CLKS)) u_pin (
        .clk(clk), .rst_n(rst_n), .pin_raw(ext_pin), .rise_ok(pin_rise)
    );

    // Per-source qualification and skip decode.
    assign qual[IDX_EXT]     = gie & ctl_q[IDX_EXT] & f_q[IDX_EXT];
    assign qual[IDX_TMR]     = gie & ctl_q[IDX_TMR] & f_q[IDX_TMR];
    assign skip_hit[IDX_EXT] = snz_ext & ~ctl_q[IDX_EXT] & f_q[IDX_EXT];
    assign skip_hit[IDX_TMR] = snz_tmr & ~ctl_q[IDX_TMR] & f_q[IDX_TMR];
    assign cond              = |qual;
    assign win_src           = qual[IDX_EXT] ? SRC_EXT : SRC_TMR;

    intr_accept_seq #(.SHORT_DLY(SHORT_DLY), .LONG_DLY(LONG_DLY)) u_seq (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick),
        .insn_single(insn_single), .cond(cond), .take(take)
    );

    assign f_set[IDX_EXT] = pin_rise;
    assign f_set[IDX_TMR] = tmr_uflow;
    assign f_clr[IDX_EXT] = skip_hit[IDX_EXT] | (take & (win_src == SRC_EXT));
    assign f_clr[IDX_TMR] = skip_hit[IDX_TMR] | (take & (win_src == SRC_TMR));

    intr_req_flags #(.N(N_SRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set(f_set), .clr(f_clr), .q(f_q)
    );

    // Control register: low-power entry clears, otherwise load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)           ctl_q <= '0;
        else if (sleep_enter) ctl_q <= '0;
        else if (ctl_wr)      ctl_q <= acc_in;
    end

    // Global enable: acceptance and DI clear it, EI sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)        gie <= 1'b0;
        else if (take)     gie <= 1'b0;
        else if (di_op)    gie <= 1'b0;
        else if (ei_op)    gie <= 1'b1;
    end

    assign ext_req  = f_q[IDX_EXT];
    assign tmr_req  = f_q[IDX_TMR];
    assign skip     = |skip_hit;
    assign take_irq = take;
    assign irq_vec  = take & (win_src == SRC_TMR);
endmodule

// File: rtl/intr_accept_chk.sv
// Property checker for the acceptance controller, bound to the top module.
// Assumes: mc_tick is a single-clock pulse and skip queries never coincide.
module intr_accept_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mc_tick,
    input logic       sleep_enter,
    input logic       snz_ext,
    input logic       snz_tmr,
    input logic [3:0] ctl_q,
    input logic       gie,
    input logic       ext_req,
    input logic       tmr_req,
    input logic       skip,
    input logic       take_irq,
    input logic       irq_vec
);
    assert_sleep_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |=> (ctl_q == 4'b0000));

    assert_take_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> gie && ((!irq_vec && ctl_q[0] && ext_req) ||
                             (irq_vec && ctl_q[1] && tmr_req)));

    assert_take_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> mc_tick);

    assert_take_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !take_irq);

    assert_gie_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |=> !gie);

    assert_ext_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && ctl_q[0] && ext_req) |-> !irq_vec);

    assert_skip_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (snz_ext && !ctl_q[0] && ext_req) || (snz_tmr && !ctl_q[1] && tmr_req));
endmodule

bind intr_accept_ctrl intr_accept_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .sleep_enter(sleep_enter),
    .snz_ext(snz_ext), .snz_tmr(snz_tmr), .ctl_q(ctl_q), .gie(gie),
    .ext_req(ext_req), .tmr_req(tmr_req), .skip(skip),
    .take_irq(take_irq), .irq_vec(irq_vec)
);

// File: tb/sim_intr_accept_ctrl.sv
module sim_intr_accept_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, mc_tick, insn_single, ext_pin, tmr_uflow;
    logic [3:0] acc_in;
    logic       ctl_wr, sleep_enter, ei_op, di_op, snz_ext, snz_tmr;
    logic [3:0] ctl_q;
    logic       gie, ext_req, tmr_req, skip, take_irq, irq_vec;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    intr_accept_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .insn_single(insn_single),
        .ext_pin(ext_pin), .tmr_uflow(tmr_uflow), .acc_in(acc_in), .ctl_wr(ctl_wr),
        .sleep_enter(sleep_enter), .ei_op(ei_op), .di_op(di_op),
        .snz_ext(snz_ext), .snz_tmr(snz_tmr), .ctl_q(ctl_q), .gie(gie),
        .ext_req(ext_req), .tmr_req(tmr_req), .skip(skip),
        .take_irq(take_irq), .irq_vec(irq_vec)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_ctl, m_gie, m_fe, m_ft, m_s1, m_s2, m_lvl, m_run, m_armed, m_left;

    function automatic int m_qe();  return m_gie & m_ctl[0] & m_fe; endfunction
    function automatic int m_qt();  return m_gie & m_ctl[1] & m_ft; endfunction
    function automatic int m_take();
        return (mc_tick && m_armed && m_left == 1 && (m_qe() || m_qt())) ? 1 : 0;
    endfunction
    function automatic int m_ske(); return snz_ext & ~m_ctl[0] & m_fe; endfunction
    function automatic int m_skt(); return snz_tmr & ~m_ctl[1] & m_ft; endfunction

    always @(posedge clk) begin
        int tk, vt, ske, skt, rise, cond;
        if (!rst_n) begin
            m_ctl = 0; m_gie = 0; m_fe = 0; m_ft = 0; m_s1 = 0; m_s2 = 0;
            m_lvl = 0; m_run = 0; m_armed = 0; m_left = 0;
        end else begin
            cond = m_qe() | m_qt();
            tk   = m_take();
            vt   = tk & ~m_qe();
            ske  = m_ske();
            skt  = m_skt();
            rise = (m_s2 != m_lvl && m_run == 4 && m_s2 == 1) ? 1 : 0;
            if (m_s2 == m_lvl) m_run = 0;
            else if (m_run == 4) begin m_lvl = m_s2; m_run = 0; end
            else m_run++;
            m_s2 = m_s1;
            m_s1 = ext_pin;
            if (!cond) m_armed = 0;
            else if (mc_tick) begin
                if (!m_armed) begin m_armed = 1; m_left = insn_single ? 2 : 3; end
                else if (m_left == 1) m_armed = 0;
                else m_left--;
            end
            m_fe = rise | (m_fe & ~(tk & ~vt) & ~ske);
            m_ft = tmr_uflow | (m_ft & ~vt & ~skt);
            if (tk) m_gie = 0; else if (di_op) m_gie = 0; else if (ei_op) m_gie = 1;
            if (sleep_enter) m_ctl = 0; else if (ctl_wr) m_ctl = acc_in;
        end
    end

    // ---------------- per-clock comparison and delay monitor ----------------
    int takes = 0;
    int waiting = 0, nticks = 0, want = 0;

    always @(negedge clk) begin
        int pc;
        if (rst_n) begin
            chk(ctl_q == m_ctl[3:0], "R1 ctl_q", ctl_q, m_ctl);
            chk(gie == m_gie[0], "R3 gie", gie, m_gie);
            chk(ext_req == m_fe[0], "R4 ext_req", ext_req, m_fe);
            chk(tmr_req == m_ft[0], "R5 tmr_req", tmr_req, m_ft);
            chk(skip == ((m_ske() | m_skt()) != 0), "R9 skip", skip, m_ske() | m_skt());
            chk(take_irq == (m_take() != 0), "R7 take_irq", take_irq, m_take());
            if (take_irq)
                chk(irq_vec == !m_qe(), "R8 irq_vec", irq_vec, !m_qe());
            pc = (gie && ((ctl_q[0] && ext_req) || (ctl_q[1] && tmr_req))) ? 1 : 0;
            if (!pc) waiting = 0;
            else if (mc_tick) begin
                if (!waiting) begin waiting = 1; nticks = 0; want = insn_single ? 2 : 3; end
                else nticks++;
            end
            if (take_irq) begin
                takes++;
                chk(nticks == want, "R7 delay ticks", nticks, want);
                waiting = 0;
            end
        end
    end

    // ---------------- machine-cycle phase generator ----------------
    int phase = 0;
    initial begin
        mc_tick = 1'b0;
        forever begin
            @(posedge clk); #1;
            phase   = (phase + 1) % 4;
            mc_tick = (phase == 3);
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr_ctl(input logic [3:0] v);
        acc_in = v; ctl_wr = 1'b1; step(1); ctl_wr = 1'b0;
    endtask

    task automatic pin_high(input int n);
        ext_pin = 1'b1; step(n); ext_pin = 1'b0; step(12);
    endtask

    task automatic wait_takes(input int target);
        int guard = 0;
        while (takes < target && guard < 200) begin step(1); guard++; end
    endtask

    // ---------------- directed stimulus ----------------
    initial begin
        int t0;
        rst_n = 1'b0; insn_single = 1'b1; ext_pin = 1'b0; tmr_uflow = 1'b0;
        acc_in = 4'h0; ctl_wr = 1'b0; sleep_enter = 1'b0; ei_op = 1'b0;
        di_op = 1'b0; snz_ext = 1'b0; snz_tmr = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
        chk(ctl_q == 4'h0, "R1 reset ctl", ctl_q, 0);
        chk(gie == 1'b0, "R3 reset gie", gie, 0);

        wr_ctl(4'b0101);
        chk(ctl_q == 4'b0101, "R1 write", ctl_q, 5);
        acc_in = 4'b1010; ctl_wr = 1'b1; sleep_enter = 1'b1; step(1);
        ctl_wr = 1'b0; sleep_enter = 1'b0;
        chk(ctl_q == 4'h0, "R2 sleep clear", ctl_q, 0);

        ei_op = 1'b1; step(1); ei_op = 1'b0;
        chk(gie == 1'b1, "R3 ei", gie, 1);
        ei_op = 1'b1; di_op = 1'b1; step(1); ei_op = 1'b0; di_op = 1'b0;
        chk(gie == 1'b0, "R3 di wins", gie, 0);

        pin_high(3);
        chk(ext_req == 1'b0, "R4 glitch ignored", ext_req, 0);
        pin_high(10);
        chk(ext_req == 1'b1, "R4 qualified level", ext_req, 1);

        snz_ext = 1'b1; #2;
        chk(skip == 1'b1, "R9 skip when disabled", skip, 1);
        step(1); snz_ext = 1'b0;
        chk(ext_req == 1'b0, "R9 skip clears flag", ext_req, 0);

        tmr_uflow = 1'b1; step(1); tmr_uflow = 1'b0;
        chk(tmr_req == 1'b1, "R5 underflow sets", tmr_req, 1);
        wr_ctl(4'b0010);
        snz_tmr = 1'b1; #2;
        chk(skip == 1'b0, "R9 no skip when enabled", skip, 0);
        step(1); snz_tmr = 1'b0;
        chk(tmr_req == 1'b1, "R9 flag kept", tmr_req, 1);

        t0 = takes; step(20);
        chk(takes == t0, "R6 no take with gie off", takes, t0);

        insn_single = 1'b1;
        ei_op = 1'b1; step(1); ei_op = 1'b0;
        wait_takes(t0 + 1);
        step(1);
        chk(tmr_req == 1'b0 && gie == 1'b0, "R8 flag and gie cleared", {gie, tmr_req}, 0);

        wr_ctl(4'b0011);
        pin_high(8);
        tmr_uflow = 1'b1; step(1); tmr_uflow = 1'b0;
        insn_single = 1'b0;
        t0 = takes;
        ei_op = 1'b1; step(1); ei_op = 1'b0;
        wait_takes(t0 + 1);
        step(1);
        chk(ext_req == 1'b0 && tmr_req == 1'b1, "R8 ext first, timer kept",
            {ext_req, tmr_req}, 1);
        insn_single = 1'b1;
        ei_op = 1'b1; step(1); ei_op = 1'b0;
        wait_takes(t0 + 2);
        step(1);
        chk(tmr_req == 1'b0, "R8 timer served next", tmr_req, 0);

        wr_ctl(4'b0001);
        pin_high(8);
        insn_single = 1'b0;
        t0 = takes;
        ei_op = 1'b1; step(1); ei_op = 1'b0;
        while (waiting == 0) step(1);
        di_op = 1'b1; step(1); di_op = 1'b0;
        step(30);
        chk(takes == t0, "R10 dropped after di", takes, t0);
        chk(ext_req == 1'b1, "R10 flag retained", ext_req, 1);

        wr_ctl(4'b1100);
        chk(ctl_q == 4'b1100, "R1 upper bits", ctl_q, 12);
        step(2);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog R7 actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule